// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides an input clock by a non-integer average ratio. It does this by using two neighbouring integer ratios, a base ratio N and N+1, and mixing them in a repeating frame. A frame is made of a programmable number of short division cycles (N input clocks each) and a programmable number of long ones (N+1 input clocks each). The average ratio over a frame is therefore (a·N + b·(N+1)) / (a + b). One example: N = 10 with nine short and one long cycle gives 10.1.

The block puts out a single-cycle pulse that marks the end of every division cycle. The spacing between pulses changes between N and N+1 inside a frame. This period jitter is intended. Configuration is taken from the input pins only at a frame boundary, so a frame always completes with the settings it started with. A synchronous reset and a clock enable control the counters. A configuration that cannot divide is held silent.

Top module: `fdiv_dual_mod`

## Requirements
- R1: Within each frame, the first `short_cnt` division cycles last exactly `ratio_n` input clocks, and the following `long_cnt` division cycles last exactly `ratio_n`+1 input clocks. The frame then repeats in the same order.
- R2: `pulse_o` is high for exactly one input clock, in the last clock of each division cycle. With `en` high from the reset-release edge on, the first pulse appears in the clock `ratio_n`-1 cycles after that edge (or `ratio_n` cycles when `short_cnt` is 0).
- R3: With `ratio_n`=10, `short_cnt`=9 and `long_cnt`=1, consecutive frames span 101 input clocks per 10 pulses, which is an average ratio of 10.1.
- R4: A clock edge with `rst` high clears the cycle and frame counters and loads the configuration pins. The next pulse then follows the R2 timing from that edge, wherever the previous count stood.
- R5: While `en` is low, every counter and the held configuration keep their values and `pulse_o` is low. When `en` returns high, counting resumes where it stopped.
- R6: Changes on `ratio_n`, `short_cnt` or `long_cnt` are ignored until the current frame ends. The held configuration changes only at a frame end, at reset, or while the held configuration is unusable.
- R7: If `short_cnt`+`long_cnt` is 0 or `ratio_n` is below 2, `pulse_o` stays low. Once a usable setting is applied, the first enabled edge loads it, and the first pulse arrives `ratio_n`-1 cycles after that edge.
- R8: A frame with `short_cnt`=0 divides by `ratio_n`+1 only. A frame with `long_cnt`=0 divides by `ratio_n` only.
- R9: `pulse_o` is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; also loads the configuration |
| en | input | 1 | Clock enable; low freezes all state and silences the output |
| ratio_n | input | NW | Base integer ratio N |
| short_cnt | input | CW | Division cycles of length N per frame |
| long_cnt | input | CW | Division cycles of length N+1 per frame |
| pulse_o | output | 1 | One-clock pulse at the end of every division cycle |

## Verification
Each fault in the state shows up as a pulse in the wrong clock, and the check looks at every clock.

- A cycle counter that is off by one moves the next pulse by one clock. This shows within at most N+1 clocks.
- A wrong frame slot or a wrong short/long boundary changes one interval inside the first frame.
- Configuration that is loaded too early shows as a new interval before the frame end.

The bench compares `pulse_o` against an independently computed pulse schedule in every sampled clock. It also covers pause/resume, mid-frame reprogramming and recovery from an unusable setting.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   // Which kind of division cycle the frame is currently in.
   typedef enum logic {
      SEG_SHORT = 1'b0,
      SEG_LONG  = 1'b1
   } seg_e;

   // Smallest base ratio the divider accepts.
   localparam int unsigned MIN_RATIO = 2;
endpackage

// File: rtl/fdiv_cfg_hold.sv
// Holds the active frame configuration; reloads only when told to.
module fdiv_cfg_hold #(
   parameter int unsigned NW = 8,
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          reload,
   input  logic [NW-1:0] n_in,
   input  logic [CW-1:0] a_in,
   input  logic [CW-1:0] b_in,
   output logic [NW-1:0] n_q,
   output logic [CW-1:0] a_q,
   output logic [CW:0]   tot_q,
   output logic          valid_q
);
   import fdiv_pkg::*;

   localparam int unsigned TW = CW + 1;

   logic          load;
   logic [TW-1:0] tot_in;
   logic          valid_in;

   assign load     = rst | (en & reload);
   assign tot_in   = {1'b0, a_in} + {1'b0, b_in};
   assign valid_in = (tot_in != '0) && (n_in >= NW'(MIN_RATIO));

   always_ff @(posedge clk) begin
      if (load) begin
         n_q     <= n_in;
         a_q     <= a_in;
         tot_q   <= tot_in;
         valid_q <= valid_in;
      end
   end

   // R6: outside a load the held settings do not move
   a_r6_cfg_stable: assert property (@(posedge clk) disable iff (rst)
      !(en && reload) |=> ($stable(n_q) && $stable(a_q) && $stable(tot_q)));
endmodule

// File: rtl/fdiv_frame_seq.sv
// Tracks the slot (division-cycle index) inside the frame.
module fdiv_frame_seq #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic          clr,
   input  logic          adv,
   input  logic [CW-1:0] a_q,
   input  logic [CW:0]   tot_q,
   output fdiv_pkg::seg_e seg,
   output logic          last_slot
);
   import fdiv_pkg::*;

   localparam int unsigned SW = CW + 1;

   logic [SW-1:0] slot;

   assign last_slot = (slot == tot_q - 1'b1);
   assign seg       = (slot >= {1'b0, a_q}) ? SEG_LONG : SEG_SHORT;

   always_ff @(posedge clk) begin
      if (rst || (en && clr)) begin
         slot <= '0;
      end else if (en && adv) begin
         slot <= last_slot ? '0 : slot + 1'b1;
      end
   end

   // R5: slot frozen while disabled
   a_r5_slot_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(slot));
   // R1: slot stays inside the frame
   a_r1_slot_range: assert property (@(posedge clk) disable iff (rst)
      (tot_q != '0) |-> (slot < tot_q));
endmodule

// File: rtl/fdiv_period_cnt.sv
// Counts input clocks within one division cycle of length N or N+1.
module fdiv_period_cnt #(
   parameter int unsigned NW = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           en,
   input  logic           clr,
   input  fdiv_pkg::seg_e seg,
   input  logic [NW-1:0]  n_q,
   output logic           term
);
   import fdiv_pkg::*;

   logic [NW-1:0] cnt;
   logic [NW-1:0] lim;

   assign lim  = (seg == SEG_LONG) ? n_q : n_q - 1'b1;
   assign term = (cnt == lim);

   always_ff @(posedge clk) begin
      if (rst || (en && clr)) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= term ? '0 : cnt + 1'b1;
      end
   end

   // R1: counting steps by one inside a division cycle
   a_r1_cnt_step: assert property (@(posedge clk) disable iff (rst)
      (en && !clr && !term) |=> (cnt == $past(cnt) + 1'b1));
   // R5: count frozen while disabled
   a_r5_cnt_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt));
endmodule

// File: rtl/fdiv_dual_mod.sv
// Dual-modulus fractional divider: short (N) then long (N+1) cycles per frame.
module fdiv_dual_mod #(
   parameter int unsigned NW        = 8,
   parameter int unsigned CW        = 8,
   parameter bit          PULSE_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [NW-1:0] ratio_n,
   input  logic [CW-1:0] short_cnt,
   input  logic [CW-1:0] long_cnt,
   output logic          pulse_o
);
   import fdiv_pkg::*;

   if (NW < 2) begin : g_nw_bad
      $error("fdiv_dual_mod: NW must be at least 2");
   end
   if (CW < 1) begin : g_cw_bad
      $error("fdiv_dual_mod: CW must be at least 1");
   end

   logic [NW-1:0] n_q;
   logic [CW-1:0] a_q;
   logic [CW:0]   tot_q;
   logic          valid_q;
   logic          term;
   logic          last_slot;
   logic          reload;
   logic          pulse_raw;
   seg_e          seg;

   // Reload at a frame end, or continuously while the held setting is unusable.
   assign reload    = ~valid_q | (term & last_slot);
   assign pulse_raw = en & valid_q & term;

   fdiv_cfg_hold #(.NW(NW), .CW(CW)) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .reload  (reload),
      .n_in    (ratio_n),
      .a_in    (short_cnt),
      .b_in    (long_cnt),
      .n_q     (n_q),
      .a_q     (a_q),
      .tot_q   (tot_q),
      .valid_q (valid_q)
   );

   fdiv_frame_seq #(.CW(CW)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .clr       (reload),
      .adv       (term),
      .a_q       (a_q),
      .tot_q     (tot_q),
      .seg       (seg),
      .last_slot (last_slot)
   );

   fdiv_period_cnt #(.NW(NW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .clr  (reload),
      .seg  (seg),
      .n_q  (n_q),
      .term (term)
   );

   if (PULSE_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (rst) pulse_q <= 1'b0;
         else     pulse_q <= pulse_raw;
      end
      assign pulse_o = pulse_q;
   end else begin : g_out_comb
      assign pulse_o = pulse_raw;
   end

   // R9: division cycles are at least two clocks long
   a_r9_pulse_gap: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);
endmodule

// File: tb/tb_fdiv_dual_mod.sv
`timescale 1ns/1ps
module tb_fdiv_dual_mod;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic [7:0] ratio_n   = 8'd4;
   logic [7:0] short_cnt = 8'd1;
   logic [7:0] long_cnt  = 8'd1;
   logic       pulse_o;

   int nchk = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fdiv_dual_mod dut (
      .clk(clk), .rst(rst), .en(en), .ratio_n(ratio_n),
      .short_cnt(short_cnt), .long_cnt(long_cnt), .pulse_o(pulse_o)
   );

   // Vector table: N, short count, long count, cycles, requirement number.
   localparam int NV = 7;
   localparam int VN[NV]   = '{10, 3, 2, 5, 4, 1, 6};
   localparam int VA[NV]   = '{ 9, 2, 1, 0, 3, 2, 0};
   localparam int VB[NV]   = '{ 1, 2, 3, 3, 0, 2, 0};
   localparam int VL[NV]   = '{260,120,120,120,120, 60, 60};
   localparam int VREQ[NV] = '{ 3, 1, 1, 8, 8, 7, 7};

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int ratio_of(input int n, input int a, input int b, input int i);
      int s;
      s = i % (a + b);
      return (s < a) ? n : n + 1;
   endfunction

   // Reset with a given setting; leaves the bench just after the release negedge.
   task automatic do_reset(input int n, input int a, input int b);
      @(negedge clk);
      rst = 1'b1; en = 1'b1;
      ratio_n = 8'(n); short_cnt = 8'(a); long_cnt = 8'(b);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   // Compare every sampled clock against the computed pulse schedule.
   task automatic run_vec(input int n, input int a, input int b, input int len, input string req);
      int  errs = 0;
      int  first_bad = -1;
      int  nxt;
      int  idx = 0;
      bit  ok_cfg;
      bit  expp;
      ok_cfg = (a + b > 0) && (n >= 2);
      do_reset(n, a, b);
      nxt = ok_cfg ? ratio_of(n, a, b, 0) - 1 : -1;
      for (int k = 0; k < len; k++) begin
         expp = ok_cfg && (k == nxt);
         if (pulse_o !== expp) begin
            errs++;
            if (first_bad < 0) first_bad = k;
         end
         if (expp) begin
            idx++;
            nxt = nxt + ratio_of(n, a, b, idx);
         end
         @(negedge clk); #1;
      end
      chk(errs == 0, req, first_bad, -1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      int t0, t10, cnt, first;

      // R4: reset state with enable high during reset
      do_reset(4, 1, 1);
      rst = 1'b1;
      @(posedge clk); @(negedge clk); #1;
      chk(pulse_o == 1'b0, "R4 reset-state", pulse_o, 0);
      rst = 1'b0;

      // Table-driven schedules (R1, R2, R3, R7, R8)
      for (int v = 0; v < NV; v++) begin
         run_vec(VN[v], VA[v], VB[v], VL[v], $sformatf("R%0d/R2 vec%0d", VREQ[v], v));
      end

      // R3: ten pulses span 101 clocks; R2 first pulse at clock 9
      do_reset(10, 9, 1);
      t0 = -1; t10 = -1; cnt = 0;
      for (int k = 0; k < 300; k++) begin
         if (pulse_o) begin
            if (cnt == 0)  t0 = k;
            if (cnt == 10) t10 = k;
            cnt++;
         end
         @(negedge clk); #1;
      end
      chk(t0 == 9, "R2 first-pulse", t0, 9);
      chk((t10 - t0) == 101, "R3 frame-span", t10 - t0, 101);

      // R4: reset mid-run restarts the schedule
      do_reset(5, 2, 2);
      repeat (7) begin @(negedge clk); end
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0; #1;
      first = -1;
      for (int k = 0; k < 20; k++) begin
         if (pulse_o && first < 0) first = k;
         @(negedge clk); #1;
      end
      chk(first == 4, "R4 mid-run-reset", first, 4);

      // R5: pause at terminal count, resume
      do_reset(4, 1, 1);
      cnt = 0;
      for (int k = 0; k < 3; k++) begin
         if (pulse_o) cnt++;
         @(negedge clk); #1;
      end
      en = 1'b0; #1;
      chk(pulse_o == 1'b0, "R5 gated-at-term", pulse_o, 0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); #1;
         if (pulse_o) cnt++;
      end
      chk(cnt == 0, "R5 silent-while-paused", cnt, 0);
      @(negedge clk);
      en = 1'b1; #1;
      chk(pulse_o == 1'b1, "R5 resume-same-count", pulse_o, 1);
      repeat (5) begin @(negedge clk); end
      #1;
      chk(pulse_o == 1'b1, "R5 long-after-resume", pulse_o, 1);

      // R6: reprogram mid-frame; old frame finishes first
      do_reset(3, 1, 1);
      cnt = 0;
      for (int k = 0; k < 22; k++) begin
         bit e;
         e = (k == 2) || (k == 6) || (k == 12) || (k == 19);
         if (pulse_o !== e) cnt++;
         if (k == 1) begin ratio_n = 8'd6; end
         @(negedge clk); #1;
      end
      chk(cnt == 0, "R6 frame-boundary-load", cnt, 0);

      // R7: unusable setting silent, then recovery timing
      do_reset(1, 1, 1);
      cnt = 0;
      for (int k = 0; k < 10; k++) begin
         if (pulse_o) cnt++;
         @(negedge clk); #1;
      end
      chk(cnt == 0, "R7 low-ratio-silent", cnt, 0);
      ratio_n = 8'd3; #1;
      first = -1;
      for (int j = 0; j < 12; j++) begin
         if (pulse_o && first < 0) first = j;
         @(negedge clk); #1;
      end
      chk(first == 3, "R7 recovery", first, 3);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule